// File: doc/BRIEF.md
# Low-Frequency Tag Load-Modulation Emulator

This block makes a chip behave like a passive low-frequency tag placed in a reader's field. A clock recovered from the reader carrier enters on `field_clk_in`. Each carrier cycle the block reads the next bit of a stored pattern and sets the coil-shunt control from it. A 1 leaves the coil open and a 0 shorts it, so the reader sees the pattern as load modulation. When the last entry has been sent, the pattern starts again from entry zero and repeats until the block is stopped. A short-coil gap of programmable length, counted in microseconds, can be placed at every wrap.

The pattern sits in a one-bit-wide internal RAM, which is loaded through a simple write port. The host sets the pattern length, the gap length and the microsecond prescaler, then raises `enable`. Dropping `enable` stops emulation at once. The coil is then left open and `running` falls.

Top module: `lf_tag_emulator`

## Requirements
- R1: Each rising edge of the synchronized field clock sets `coil_open` to the current pattern bit, where a 1 means open and a 0 means shorted. `coil_open` shows the new value within 3 system clocks of the edge reaching `field_clk_in`.
- R2: The pattern index advances only on a falling edge of the field clock, so exactly one pattern entry is used per field-clock cycle.
- R3: After entry `pat_len`-1 has been used, the index returns to 0 and the pattern repeats for as long as the block stays enabled.
- R4: If `gap_us` is non-zero, then at each wrap `coil_open` is held at 0 for `gap_us` microseconds. During this time field-clock edges are ignored and `running` stays 1. Emulation then resumes at entry 0.
- R5: If `gap_us` is 0, no gap is inserted at the wrap, and the next field-clock cycle uses entry 0.
- R6: A low `enable` in any active phase (waiting for high, waiting for low, or in a gap) clears `running` and opens the coil on the next clock. The next start begins at entry 0.
- R7: If `pat_len` is 0, the block stays idle with `running` at 0, even when `enable` is high.
- R8: After reset, `running` is 0 and `coil_open` is 1.
- R9: A write with `wr_en` high stores `wr_data` at entry `wr_addr`. One microsecond lasts `us_div`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_clk_in | input | 1 | Clock recovered from the reader carrier, asynchronous to `clk` |
| enable | input | 1 | High to emulate; low aborts |
| pat_len | input | 11 | Number of pattern entries; captured at start |
| gap_us | input | 16 | Short-coil gap at each wrap, in microseconds; 0 means no gap |
| us_div | input | 8 | System clocks per microsecond, minus one |
| wr_en | input | 1 | Pattern RAM write strobe |
| wr_addr | input | 11 | Pattern RAM write entry |
| wr_data | input | 1 | Pattern bit to store |
| coil_open | output | 1 | 1 = coil open, 0 = coil shorted |
| running | output | 1 | High while emulation is active |

## Verification
The bench uses an eight-entry pattern that is not symmetric and runs it with a length of 5 over twelve field cycles. Entry 5 differs from entry 0, so the expected stream exposes a wrap at the wrong index, a skipped or repeated entry, and a missing wrap. A four-entry run whose last bit is 1 is followed by a field pulse placed inside the gap. A shorted coil there separates a real gap from none, and the value after the gap shows whether the timer ended and emulation resumed at entry 0. Aborts in both waiting phases, restart from entry 0, and a zero length give the stop and idle cases.

// File: rtl/lfemu_pkg.sv
// Package: shared types for the low-frequency tag emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package lfemu_pkg;

    // Sequencer phases of the emulator.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HI = 2'd1,
        ST_WAIT_LO = 2'd2,
        ST_GAP     = 2'd3
    } emu_state_t;

endpackage

// File: rtl/field_edge_sync.sv
// Module: field_edge_sync
// Brings the asynchronous field clock into the clk domain through two flops,
// then reports one-cycle rise and fall pulses from a registered level change.
// Assumes: field clock phases last at least two system clocks.
module field_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchronizer plus the delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses from the level change between the last two samples.
    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/pattern_ram.sv
// Module: pattern_ram
// One-bit-wide pattern store with a single write port and a registered read.
// Assumes: the read address is stable for a cycle before the data is used.
module pattern_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] mem;

    // Write port: store one bit per strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read of the entry at the current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit <= 1'b0;
        end else begin
            rd_bit <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/gap_timer.sv
// Module: gap_timer
// Divides clk into a microsecond strobe and counts a gap of gap_len strobes.
// Assumes: start is never issued with gap_len equal to zero.
module gap_timer #(
    parameter int GAP_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [GAP_W-1:0] gap_len,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             done
);
    logic [DIV_W-1:0] pre_q;
    logic [GAP_W-1:0] remain_q;
    logic             tick;

    // Microsecond strobe: one cycle every div+1 clocks while counting.
    always_comb begin
        tick = busy && (pre_q == div);
        done = tick && (remain_q == GAP_W'(1));
    end

    // Prescaler and remaining-microsecond counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            remain_q <= '0;
            busy     <= 1'b0;
        end else if (stop) begin
            pre_q    <= '0;
            remain_q <= '0;
            busy     <= 1'b0;
        end else if (start) begin
            pre_q    <= '0;
            remain_q <= gap_len;
            busy     <= 1'b1;
        end else if (busy) begin
            if (tick) begin
                pre_q    <= '0;
                remain_q <= remain_q - GAP_W'(1);
                if (remain_q == GAP_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                pre_q <= pre_q + DIV_W'(1);
            end
        end
    end

    AST_GAP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R4

endmodule

// File: rtl/lf_tag_emulator.sv
// Module: lf_tag_emulator
// Emulates a passive LF tag. On each field-clock rise the coil is set from the
// current pattern bit. On each fall the index advances, wrapping at the
// captured length, with an optional timed short-coil gap at the wrap.
// Assumes: the field clock is much slower than clk; pat_len is held at start.
module lf_tag_emulator #(
    parameter int ADDR_W = 11,
    parameter int GAP_W  = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_clk_in,
    input  logic              enable,
    input  logic [ADDR_W-1:0] pat_len,
    input  logic [GAP_W-1:0]  gap_us,
    input  logic [DIV_W-1:0]  us_div,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output logic              coil_open,
    output logic              running
);
    import lfemu_pkg::*;

    localparam logic [ADDR_W-1:0] IDX_ONE = ADDR_W'(1);

    emu_state_t        state_q;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] len_q;
    logic              fld_rise;
    logic              fld_fall;
    logic              pat_bit;
    logic              gap_busy;
    logic              gap_done;
    logic              at_last;
    logic              gap_start;
    logic              gap_stop;

    field_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (field_clk_in),
        .rise     (fld_rise),
        .fall     (fld_fall)
    );

    pattern_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (idx_q),
        .rd_bit  (pat_bit)
    );

    gap_timer #(.GAP_W(GAP_W), .DIV_W(DIV_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .stop    (gap_stop),
        .gap_len (gap_us),
        .div     (us_div),
        .busy    (gap_busy),
        .done    (gap_done)
    );

    // Wrap detection and gap timer control.
    always_comb begin
        at_last   = (idx_q == len_q - IDX_ONE);
        gap_start = (state_q == ST_WAIT_LO) && enable && fld_fall && at_last
                    && (gap_us != '0);
        gap_stop  = (state_q == ST_GAP) && !enable;
    end

    // Sequencer: edge-driven pattern playback, wrap, gap and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            len_q     <= '0;
            coil_open <= 1'b1;
            running   <= 1'b0;
        end else if (state_q != ST_IDLE && !enable) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            coil_open <= 1'b1;
            running   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    idx_q     <= '0;
                    coil_open <= 1'b1;
                    if (enable && pat_len != '0) begin
                        len_q   <= pat_len;
                        running <= 1'b1;
                        state_q <= ST_WAIT_HI;
                    end
                end
                ST_WAIT_HI: begin
                    if (fld_rise) begin
                        coil_open <= pat_bit;
                        state_q   <= ST_WAIT_LO;
                    end
                end
                ST_WAIT_LO: begin
                    if (fld_fall) begin
                        if (at_last) begin
                            idx_q <= '0;
                            if (gap_us != '0) begin
                                coil_open <= 1'b0;
                                state_q   <= ST_GAP;
                            end else begin
                                state_q <= ST_WAIT_HI;
                            end
                        end else begin
                            idx_q   <= idx_q + IDX_ONE;
                            state_q <= ST_WAIT_HI;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_done) begin
                        state_q <= ST_WAIT_HI;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fld_rise, fld_fall})); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + IDX_ONE || idx_q == '0)); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (idx_q < len_q)); // R3
    AST_GAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (!coil_open && running)); // R4
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !enable) |=> (!running && coil_open)); // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && pat_len == '0) |=> !running); // R7

endmodule

// File: tb/lf_tag_emulator_test.sv
// Bench: scoreboard for lf_tag_emulator. The driver pushes the expected coil
// level for each field cycle. The monitor pops it and compares mid-phase.
module lf_tag_emulator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_clk_in = 1'b0;
    logic        enable = 1'b0;
    logic [10:0] pat_len = '0;
    logic [15:0] gap_us = '0;
    logic [7:0]  us_div = 8'd49;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic        wr_data = 1'b0;
    logic        coil_open;
    logic        running;

    int tests_run = 0;
    int tests_failed = 0;
    logic  exp_q[$];
    string tag_q[$];
    event  mon_ev;
    logic  model [0:7] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    always #10 clk = ~clk;

    lf_tag_emulator uut (
        .clk(clk), .rst_n(rst_n), .field_clk_in(field_clk_in), .enable(enable),
        .pat_len(pat_len), .gap_us(gap_us), .us_div(us_div), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .coil_open(coil_open), .running(running)
    );

    // Direct check of a port value.
    task automatic check(input string tag, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected coil level per sample request.
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() != 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, coil_open, e);
            end
        end
    end

    // Driver: one field-clock cycle, with the expected level sampled mid-high.
    task automatic field_cycle(input logic exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk) field_clk_in = 1'b1;
        repeat (6) @(negedge clk);
        -> mon_ev;
        field_clk_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(a); wr_data = d;
        @(negedge clk) wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 running after reset", running, 1'b0);
        check("R8 coil after reset", coil_open, 1'b1);

        for (int i = 0; i < 8; i++) wr(i, model[i]); // R9 loaded through write port

        // R7: zero length keeps the block idle
        pat_len = 11'd0; enable = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 zero length idle", running, 1'b0);
        enable = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R5: length 5, no gap, twelve cycles across two wraps
        pat_len = 11'd5; gap_us = 16'd0; enable = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 running after start", running, 1'b1);
        for (int i = 0; i < 12; i++) field_cycle(model[i % 5], "R1/R2/R3/R5 pattern stream");

        // R6: abort while waiting for the fall
        @(negedge clk) field_clk_in = 1'b1;
        repeat (6) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 abort in high phase running", running, 1'b0);
        check("R6 abort in high phase coil", coil_open, 1'b1);
        field_clk_in = 1'b0;
        repeat (6) @(negedge clk);

        // R6: restart begins at entry 0, then abort while waiting for the rise
        enable = 1'b1;
        repeat (2) @(negedge clk);
        field_cycle(model[0], "R6 restart at entry 0");
        field_cycle(model[1], "R6 second entry after restart");
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 abort in low phase running", running, 1'b0);
        check("R6 abort in low phase coil", coil_open, 1'b1);

        // R4: length 4 (last bit 1), 3 us gap at 50 clocks per us
        pat_len = 11'd4; gap_us = 16'd3; enable = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) field_cycle(model[i], "R4 run before gap");
        check("R4 running during gap", running, 1'b1);
        repeat (110) @(negedge clk);
        exp_q.push_back(1'b0);
        tag_q.push_back("R4 coil shorted, edge ignored in gap");
        field_clk_in = 1'b1;
        repeat (6) @(negedge clk);
        -> mon_ev;
        field_clk_in = 1'b0;
        repeat (106) @(negedge clk);
        field_cycle(model[0], "R4 resume at entry 0 after gap");
        field_cycle(model[1], "R4 second entry after gap");
        check("R4 still running after gap", running, 1'b1);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule